// File: doc/BRIEF.md
# Reset Source Controller and Status

This block merges every reset request in the chip into one system reset and keeps a byte of status that says which source caused the most recent reset. Its sources are the already synchronized external reset pin (active low), a missing-clock timeout, a comparator-low indication, a watchdog expiry and a flash-access-violation pulse. The missing-clock and comparator sources are gated by enable bits, and software sets these enables through a register write port.

Some status bits have two roles. On read they are cause flags. On write, bits 2 and 5 set the enables for the missing-clock and comparator sources, and the write does not touch the flag in that position. The system reset is held for a fixed number of cycles after the last request goes away, so that downstream logic always sees a reset pulse of a known length. The block only reads the external pin and never drives it. The internal sources therefore never change the pin.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `extRstN` is low, `sysRst` is high and both enables are cleared. After release, `status` reads 0x01 (bit 0 is the external-pin flag).
- R2: A `wdtExpire` request causes a reset. Afterwards `status` reads 0x08 (bit 3 is the watchdog flag).
- R3: A `flashErr` request causes a reset. Afterwards `status` reads 0x40 (bit 6 is the flash-violation flag).
- R4: `mcdTimeout` causes a reset only while the missing-clock enable is 1. Afterwards `status` reads 0x04 (bit 2). While the enable is 0, the input is ignored.
- R5: `cmpLow` causes a reset only while the comparator enable is 1. Afterwards `status` reads 0x20 (bit 5). While the enable is 0, the input is ignored.
- R6: An accepted write (`wrEn` high) loads the missing-clock enable from `wrData[2]` and the comparator enable from `wrData[5]`. A write never changes `status`. A write is ignored while `sysRst` is high or `extRstN` is low.
- R7: Both enables keep their value across resets caused by internal sources.
- R8: A reset that starts while `sysRst` is low clears every cause flag except those of the requesting sources. Status bits 1, 4 and 7 always read 0.
- R9: Sources that request in the same cycle all set their flags. A request that arrives while `sysRst` is still high adds its flag to the flags already set.
- R10: `sysRst` rises at the first clock edge that samples a request. It falls at the 8th (`STRETCH_CYCLES`) edge after the last edge that sampled a request. A one-cycle request therefore gives an 8-cycle reset, and an N-cycle request gives N+7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| extRstN | input | 1 | Synchronized external reset pin, active low |
| mcdTimeout | input | 1 | Missing-clock timeout request |
| cmpLow | input | 1 | Comparator reports non-inverting input below inverting input |
| wdtExpire | input | 1 | Watchdog expiry request |
| flashErr | input | 1 | Flash access violation pulse |
| wrEn | input | 1 | Status/enable register write strobe |
| wrData | input | 8 | Write data (bit 2 = missing-clock enable, bit 5 = comparator enable) |
| sysRst | output | 1 | System reset, active high |
| status | output | 8 | Cause flags of the most recent reset |

## Verification
Each source is fired alone, with pulses of one and of several cycles, so that the measured reset length separates the stretch rule from plain pass-through. The gated sources are fired once with the enable set and once with it cleared. This separates true gating from unconditional requests, and a write of the flag-position bits shows whether writes leak into the flags. Two sources in the same cycle, and a second source that arrives while the reset is still stretched, separate replacing the flags from merging them. An external reset after the enables are set, and a write issued during a reset, show which events are allowed to clear or load the enables.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  // Status byte positions (software decodes these)
  localparam int BIT_PIN   = 0;
  localparam int BIT_MCD   = 2;
  localparam int BIT_WDT   = 3;
  localparam int BIT_CMP   = 5;
  localparam int BIT_FLASH = 6;

  typedef struct packed {
    logic flash;
    logic wdt;
    logic cmp;
    logic mcd;
    logic pin;
  } causes_t;

  typedef struct packed {
    logic loadCauses;   // start of a fresh reset: replace flags
    logic mergeCauses;  // request while reset already active: add flags
    logic clearEnables; // external pin reset clears enables
    logic takeWrite;    // accepted register write
  } ctlStrobes_t;
endpackage

// File: rtl/rst_src_ctl.sv
module rst_src_ctl
  import rst_src_pkg::*;
#(
  parameter int STRETCH_CYCLES = 8
) (
  input  logic        clk,
  input  logic        extRstN,
  input  logic        mcdTimeout,
  input  logic        cmpLow,
  input  logic        wdtExpire,
  input  logic        flashErr,
  input  logic        wrEn,
  input  logic        mcdEn,
  input  logic        cmpEn,
  output causes_t     newCauses,
  output ctlStrobes_t strobes,
  output logic        sysRst
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);

  logic [CNT_W-1:0] stretchCnt;
  logic anyReq;
  logic inReset;

  always_comb begin
    newCauses.pin   = ~extRstN;
    newCauses.mcd   = mcdTimeout & mcdEn;
    newCauses.cmp   = cmpLow & cmpEn;
    newCauses.wdt   = wdtExpire;
    newCauses.flash = flashErr;
  end

  assign anyReq  = |newCauses;
  assign inReset = (stretchCnt != '0);
  assign sysRst  = inReset;

  always_comb begin
    strobes.loadCauses   = anyReq & (~extRstN | ~inReset);
    strobes.mergeCauses  = anyReq & extRstN & inReset;
    strobes.clearEnables = ~extRstN;
    strobes.takeWrite    = wrEn & extRstN & ~inReset;
  end

  always_ff @(posedge clk) begin
    if (anyReq)
      stretchCnt <= CNT_LOAD;
    else if (inReset)
      stretchCnt <= stretchCnt - 1'b1;
  end

  // Independent checker counter: cycles since the last sampled request
  logic [CNT_W-1:0] quietCnt;
  always_ff @(posedge clk) begin
    if (anyReq)
      quietCnt <= '0;
    else if (quietCnt < CNT_LOAD)
      quietCnt <= quietCnt + 1'b1;
  end

  // R10: an unconditional request is followed by reset on the next cycle
  a_r10_request_asserts_reset: assert property (@(posedge clk) disable iff (!extRstN)
    (wdtExpire || flashErr) |=> sysRst);

  // R10: reset window matches the distance from the last request
  a_r10_stretch_window: assert property (@(posedge clk) disable iff (!extRstN)
    sysRst == (quietCnt < CNT_LOAD));

  // R6: writes are never accepted during an active reset
  a_r6_no_write_in_reset: assert property (@(posedge clk) disable iff (!extRstN)
    sysRst |-> !strobes.takeWrite);
endmodule

// File: rtl/rst_src_status.sv
module rst_src_status
  import rst_src_pkg::*;
(
  input  logic        clk,
  input  logic        extRstN,
  input  ctlStrobes_t strobes,
  input  causes_t     newCauses,
  input  logic [7:0]  wrData,
  output logic        mcdEn,
  output logic        cmpEn,
  output logic [7:0]  status
);
  causes_t flags;

  always_ff @(posedge clk) begin
    if (strobes.loadCauses)
      flags <= newCauses;
    else if (strobes.mergeCauses)
      flags <= flags | newCauses;
  end

  always_ff @(posedge clk) begin
    if (strobes.clearEnables) begin
      mcdEn <= 1'b0;
      cmpEn <= 1'b0;
    end else if (strobes.takeWrite) begin
      mcdEn <= wrData[BIT_MCD];
      cmpEn <= wrData[BIT_CMP];
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_PIN]   = flags.pin;
    status[BIT_MCD]   = flags.mcd;
    status[BIT_WDT]   = flags.wdt;
    status[BIT_CMP]   = flags.cmp;
    status[BIT_FLASH] = flags.flash;
  end

  // R8: flags move only when the control reports a reset event
  a_r8_flags_hold_outside_reset: assert property (@(posedge clk) disable iff (!extRstN)
    !$past(strobes.loadCauses || strobes.mergeCauses) |-> $stable(flags));

  // R7: enables survive everything except an accepted write or the pin
  a_r7_enables_keep: assert property (@(posedge clk) disable iff (!extRstN)
    ($past(extRstN) && !$past(strobes.takeWrite)) |-> $stable({mcdEn, cmpEn}));

  // R6: accepted write lands in the enables
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!extRstN)
    $past(strobes.takeWrite) |-> (mcdEn == $past(wrData[BIT_MCD]) && cmpEn == $past(wrData[BIT_CMP])));
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter int STRETCH_CYCLES = 8
) (
  input  logic       clk,
  input  logic       extRstN,
  input  logic       mcdTimeout,
  input  logic       cmpLow,
  input  logic       wdtExpire,
  input  logic       flashErr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic       sysRst,
  output logic [7:0] status
);
  causes_t     newCauses;
  ctlStrobes_t strobes;
  logic        mcdEn;
  logic        cmpEn;

  rst_src_ctl #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_ctl (
    .clk(clk), .extRstN(extRstN), .mcdTimeout(mcdTimeout), .cmpLow(cmpLow),
    .wdtExpire(wdtExpire), .flashErr(flashErr), .wrEn(wrEn),
    .mcdEn(mcdEn), .cmpEn(cmpEn), .newCauses(newCauses),
    .strobes(strobes), .sysRst(sysRst)
  );

  rst_src_status u_status (
    .clk(clk), .extRstN(extRstN), .strobes(strobes), .newCauses(newCauses),
    .wrData(wrData), .mcdEn(mcdEn), .cmpEn(cmpEn), .status(status)
  );
endmodule

// File: tb/rst_src_ctrl_test.sv
module rst_src_ctrl_test;
  logic       clk = 1'b0;
  logic       extRstN = 1'b0;
  logic       mcdTimeout = 1'b0;
  logic       cmpLow = 1'b0;
  logic       wdtExpire = 1'b0;
  logic       flashErr = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       sysRst;
  logic [7:0] status;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_src_ctrl uut (
    .clk(clk), .extRstN(extRstN), .mcdTimeout(mcdTimeout), .cmpLow(cmpLow),
    .wdtExpire(wdtExpire), .flashErr(flashErr), .wrEn(wrEn), .wrData(wrData),
    .sysRst(sysRst), .status(status)
  );

  typedef struct {
    string      tag;
    int         len;
    logic [7:0] st;
  } expItem_t;

  expItem_t expQ[$];

  task automatic expectReset(input string tag, input int len, input logic [7:0] st);
    expItem_t it;
    it.tag = tag; it.len = len; it.st = st;
    expQ.push_back(it);
  endtask

  // src bits: 0 mcd, 1 cmp, 2 wdt, 3 flash
  task automatic pulseReq(input logic [3:0] src, input int n);
    @(negedge clk);
    mcdTimeout = src[0]; cmpLow = src[1]; wdtExpire = src[2]; flashErr = src[3];
    repeat (n) @(negedge clk);
    mcdTimeout = 1'b0; cmpLow = 1'b0; wdtExpire = 1'b0; flashErr = 1'b0;
  endtask

  task automatic pinReset(input int n);
    @(negedge clk);
    extRstN = 1'b0;
    repeat (n) @(negedge clk);
    extRstN = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expectQuiet(input string tag, input int n, input logic [7:0] st);
    bit bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (sysRst !== 1'b0) bad = 1;
    end
    tests++;
    if (bad) begin
      fails++;
      $display("FAIL %s: sysRst actual 1 expected 0 (input should be ignored)", tag);
    end
    tests++;
    if (status !== st) begin
      fails++;
      $display("FAIL %s: status actual %02h expected %02h", tag, status, st);
    end
  endtask

  // Monitor: measure each reset run, pop and compare at its falling end
  int runLen = 0;
  always @(negedge clk) begin
    if (sysRst === 1'b1) begin
      runLen++;
    end else if (runLen > 0) begin
      if (expQ.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected reset: length actual %0d expected none", runLen);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        tests++;
        if (runLen != it.len) begin
          fails++;
          $display("FAIL %s: reset length actual %0d expected %0d", it.tag, runLen, it.len);
        end
        tests++;
        if (status !== it.st) begin
          fails++;
          $display("FAIL %s: status actual %02h expected %02h", it.tag, status, it.st);
        end
      end
      runLen = 0;
    end
  end

  initial begin
    // R1 / R10: pin low for 4 edges from time zero -> 4+7 cycles, flag 0x01
    expectReset("R1 pin reset at start", 11, 8'h01);
    repeat (4) @(negedge clk);
    extRstN = 1'b1;
    waitDrain();

    // R4 enables cleared by the pin: missing clock ignored
    pulseReq(4'b0001, 2);
    expectQuiet("R4 mcd disabled after R1", 12, 8'h01);

    // R2 / R8: watchdog, one cycle
    expectReset("R2 watchdog", 8, 8'h08);
    pulseReq(4'b0100, 1);
    waitDrain();

    // R3 / R8: flash violation
    expectReset("R3 flash violation", 8, 8'h40);
    pulseReq(4'b1000, 1);
    waitDrain();

    // R5 comparator still disabled
    pulseReq(4'b0010, 1);
    expectQuiet("R5 cmp disabled", 12, 8'h40);

    // R6 / R4: enable missing clock, 3-cycle request -> 10
    writeReg(8'h04);
    expectQuiet("R6 write leaves flags", 2, 8'h40);
    expectReset("R4 mcd enabled R10 length", 10, 8'h04);
    pulseReq(4'b0001, 3);
    waitDrain();

    // R7: enable survives internal reset
    expectReset("R7 mcd enable kept", 8, 8'h04);
    pulseReq(4'b0001, 1);
    waitDrain();

    // R6: switch to comparator only; mcd now ignored
    writeReg(8'h20);
    pulseReq(4'b0001, 1);
    expectQuiet("R6 mcd disabled by write", 12, 8'h04);
    expectReset("R5 cmp enabled", 9, 8'h20);
    pulseReq(4'b0010, 2);
    waitDrain();

    // R9: comparator arrives while watchdog reset still stretched -> merged, 11 cycles
    expectReset("R9 merge during reset", 11, 8'h28);
    pulseReq(4'b0100, 1);
    repeat (1) @(negedge clk);
    pulseReq(4'b0010, 1);
    waitDrain();

    // R6: writing flag positions changes nothing; both enables now 0
    writeReg(8'h49);
    expectQuiet("R6 flag bits not writable", 2, 8'h28);
    pulseReq(4'b0011, 1);
    expectQuiet("R6 enables cleared by write", 12, 8'h28);

    // R1: enable both, then pin reset clears them
    writeReg(8'h24);
    expectReset("R1 pin reset after enables", 9, 8'h01);
    pinReset(2);
    waitDrain();
    pulseReq(4'b0011, 1);
    expectQuiet("R1 enables cleared by pin", 12, 8'h01);

    // R6: write during an active reset is dropped
    expectReset("R6 write during reset", 8, 8'h08);
    pulseReq(4'b0100, 1);
    writeReg(8'h24);
    waitDrain();
    pulseReq(4'b0011, 1);
    expectQuiet("R6 write in reset ignored", 12, 8'h08);

    // R9 / R8: two sources in one cycle
    expectReset("R9 simultaneous", 8, 8'h48);
    pulseReq(4'b1100, 1);
    waitDrain();

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule